// File: doc/BRIEF.md
# Dead-Band Timer Counter PWM

This block is a 16-bit timer/counter that turns a free-running or single-shot count into a pair of complementary PWM drives. The count runs up from zero to a programmed terminal value, or down from that value to zero. At the terminal point it either wraps around or halts, depending on a mode bit. A compare value sets the duty: the raw PWM is high while the count is below it. The raw waveform is split into a true output and an inverted output. After every raw edge, a programmable number of clock cycles passes with both outputs low, so the two switches of a half bridge are never on together.

An external event line, resynchronised inside the block, copies the live count into a capture register. An asynchronous shutdown input overrides both drives with safe levels taken from the control register. The override acts through logic only, so no clock is needed for it to take effect. It stays in force after the input drops, until the next terminal count or until the counter is stopped. Single-cycle pulses mark wrap-up, wrap-down and compare equality. Software sets everything through a small register port. New period and compare values are staged and are only adopted at a terminal count.

Register addresses: 0 control, 1 period, 2 compare, 3 dead time, 4 capture (read only), 5 live count (read only). Control bits: bit 0 run, bit 1 single-shot, bit 2 count down, bit 3 safe level of `pwm_out`, bit 4 safe level of `pwm_nout`.

Top module: `deadband_pwm`

## Requirements
- R1: With run=1 and count-down=0, the count goes 0,1,…,P and then returns to 0. The `ovf` pulse is high for one cycle at each wrap, so wraps are P+1 cycles apart. `und` stays low.
- R2: With count-down=1, the count goes P,P-1,…,0 and then returns to P. The `und` pulse is high for one cycle at each wrap, P+1 cycles apart. `ovf` stays low.
- R3: With single-shot=1, the counter halts at its terminal value: P when counting up, 0 when counting down. The run bit (control bit 0) then reads back 0, the live count holds, and no further wrap pulses appear.
- R4: With dead time 0, the raw PWM is high while the count is below the compare value C (C ≤ P). `pwm_out` is then high C cycles per period and `pwm_nout` is high P+1-C cycles per period.
- R5: `match` pulses once per period, when the count equals C.
- R6: After every raw PWM edge, both outputs stay low for D cycles, where D is the dead-time register. This makes `pwm_out` high C-D cycles and `pwm_nout` high P+1-C-D cycles per period. Outside a shutdown the two are never high together.
- R7: Period and compare writes made while running take effect only at the next wrap. The wrap interval in progress keeps the old length.
- R8: A rising edge on `cap_in` (held at least two cycles) stores the live count into the capture register.
- R9: While `kill_in` is high, `pwm_out` and `pwm_nout` equal control bits 3 and 4 without waiting for a clock edge. After release they keep those levels until the next wrap, or until the counter is stopped.
- R10: After reset, and whenever the counter is not running, both drives and all pulses are low and the count reads 0 until the first start.
- R11: Reads return the written control, period, compare and dead-time values, zero-extended, one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, registered |
| cap_in | input | 1 | Asynchronous capture event |
| kill_in | input | 1 | Asynchronous shutdown |
| pwm_out | output | 1 | True PWM drive |
| pwm_nout | output | 1 | Complementary PWM drive |
| ovf | output | 1 | Wrap pulse when counting up |
| und | output | 1 | Wrap pulse when counting down |
| match | output | 1 | Count-equals-compare pulse |

## Verification
The hardest case to reach is the shutdown hold. The drives must stay at their safe levels after `kill_in` falls and then resume exactly at the next wrap. That requires a running counter, a release part-way through a period, and a check on every cycle up to the wrap pulse. The bench gets there by asserting the shutdown between clock edges and checking the drives before any edge has passed. It then releases the shutdown mid-period and checks the safe levels on each cycle until `ovf` shows. Finally it measures duty over whole periods to confirm normal drive has resumed. Staged period writes are checked the same way, by locking onto a wrap pulse before writing and then timing two successive wrap intervals.

// File: rtl/dbpwm_pkg.sv
package dbpwm_pkg;
  localparam int ADDR_W = 3;
  localparam int CTRL_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL   = 3'd0,
    RA_PERIOD = 3'd1,
    RA_CMP    = 3'd2,
    RA_DEAD   = 3'd3,
    RA_CAPT   = 3'd4,
    RA_COUNT  = 3'd5
  } reg_addr_e;

  // bit 0 run, 1 single-shot, 2 count down, 3 safe out, 4 safe nout
  typedef struct packed {
    logic safe_n;
    logic safe_o;
    logic down;
    logic oneshot;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/dbpwm_regs.sv
module dbpwm_regs
  import dbpwm_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [CW-1:0]       wdata,
  output logic [CW-1:0]       rdata,
  input  logic                stop_req,
  input  logic [CW-1:0]       cap_val,
  input  logic [CW-1:0]       cnt_val,
  output ctrl_t               ctrl_q,
  output logic [CW-1:0]       per_buf,
  output logic [CW-1:0]       cmp_buf,
  output logic [DW-1:0]       dead_q
);
  localparam int CPAD = CW - CTRL_W;
  localparam int DPAD = CW - DW;

  logic [CW-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      per_buf <= '0;
      cmp_buf <= '0;
      dead_q  <= '0;
    end else begin
      if (stop_req) ctrl_q.run <= 1'b0;
      if (wr) begin
        case (addr)
          RA_CTRL:   ctrl_q  <= ctrl_t'(wdata[CTRL_W-1:0]);
          RA_PERIOD: per_buf <= wdata;
          RA_CMP:    cmp_buf <= wdata;
          RA_DEAD:   dead_q  <= wdata[DW-1:0];
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      RA_CTRL:   rd_mux = {{CPAD{1'b0}}, ctrl_q};
      RA_PERIOD: rd_mux = per_buf;
      RA_CMP:    rd_mux = cmp_buf;
      RA_DEAD:   rd_mux = {{DPAD{1'b0}}, dead_q};
      RA_CAPT:   rd_mux = cap_val;
      RA_COUNT:  rd_mux = cnt_val;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/dbpwm_counter.sv
module dbpwm_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          oneshot,
  input  logic          down,
  input  logic [CW-1:0] per_buf,
  input  logic [CW-1:0] cmp_buf,
  output logic [CW-1:0] count,
  output logic [CW-1:0] per_sh,
  output logic          active,
  output logic          tc,
  output logic          stop_req,
  output logic          ovf,
  output logic          und,
  output logic          match,
  output logic          raw
);
  logic          run_d;
  logic [CW-1:0] cmp_sh;
  logic [CW-1:0] reload_val;

  assign active     = run & run_d;
  assign tc         = active & (down ? (count == '0) : (count == per_sh));
  assign stop_req   = tc & oneshot;
  assign reload_val = down ? per_buf : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_d  <= 1'b0;
      count  <= '0;
      per_sh <= '0;
      cmp_sh <= '0;
      ovf    <= 1'b0;
      und    <= 1'b0;
      match  <= 1'b0;
      raw    <= 1'b0;
    end else begin
      run_d <= run;
      ovf   <= tc & ~down;
      und   <= tc & down;
      match <= active & (count == cmp_sh);
      raw   <= active & (count < cmp_sh);
      if (!run) begin
        per_sh <= per_buf;
        cmp_sh <= cmp_buf;
      end else if (!run_d) begin
        per_sh <= per_buf;
        cmp_sh <= cmp_buf;
        count  <= reload_val;
      end else if (tc) begin
        if (!oneshot) begin
          per_sh <= per_buf;
          cmp_sh <= cmp_buf;
          count  <= reload_val;
        end
      end else if (down) begin
        count <= count - 1'b1;
      end else begin
        count <= count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbpwm_capture.sv
module dbpwm_capture #(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_in,
  input  logic [CW-1:0] count,
  output logic [CW-1:0] cap_val
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      cap_val <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], cap_in};
      prev_q <= synced;
      if (synced && !prev_q) cap_val <= count;
    end
  end
endmodule

// File: rtl/dbpwm_deadband.sv
module dbpwm_deadband #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          raw,
  input  logic [DW-1:0] dead,
  output logic          out_q,
  output logic          nout_q
);
  logic          raw_d;
  logic [DW-1:0] dcnt;
  logic [DW-1:0] dnext;
  logic          quiet;

  always_comb begin
    if (raw != raw_d)     dnext = dead;
    else if (dcnt != '0)  dnext = dcnt - 1'b1;
    else                  dnext = '0;
  end

  assign quiet = (dnext == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_d  <= 1'b0;
      dcnt   <= '0;
      out_q  <= 1'b0;
      nout_q <= 1'b0;
    end else begin
      raw_d  <= raw;
      dcnt   <= dnext;
      out_q  <= en & raw & quiet;
      nout_q <= en & ~raw & quiet;
    end
  end
endmodule

// File: rtl/deadband_pwm.sv
module deadband_pwm
  import dbpwm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DEAD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              cap_in,
  input  logic              kill_in,
  output logic              pwm_out,
  output logic              pwm_nout,
  output logic              ovf,
  output logic              und,
  output logic              match
);
  ctrl_t              ctrl_q;
  logic [CNT_W-1:0]   per_buf, cmp_buf, per_sh, count, cap_val;
  logic [DEAD_W-1:0]  dead_q;
  logic               active, tc, stop_req, raw;
  logic               db_out, db_nout;
  logic               kill_hold, kill_act;

  dbpwm_regs #(.CW(CNT_W), .DW(DEAD_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .stop_req(stop_req), .cap_val(cap_val), .cnt_val(count),
    .ctrl_q(ctrl_q), .per_buf(per_buf), .cmp_buf(cmp_buf), .dead_q(dead_q)
  );

  dbpwm_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .oneshot(ctrl_q.oneshot),
    .down(ctrl_q.down), .per_buf(per_buf), .cmp_buf(cmp_buf), .count(count),
    .per_sh(per_sh), .active(active), .tc(tc), .stop_req(stop_req),
    .ovf(ovf), .und(und), .match(match), .raw(raw)
  );

  dbpwm_capture #(.CW(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk(clk), .rst(rst), .cap_in(cap_in), .count(count), .cap_val(cap_val)
  );

  dbpwm_deadband #(.DW(DEAD_W)) u_db (
    .clk(clk), .rst(rst), .en(active), .raw(raw), .dead(dead_q),
    .out_q(db_out), .nout_q(db_nout)
  );

  always_ff @(posedge clk) begin
    if (rst)                         kill_hold <= 1'b0;
    else if (kill_in)                kill_hold <= 1'b1;
    else if (tc || !ctrl_q.run)      kill_hold <= 1'b0;
  end

  assign kill_act = kill_in | kill_hold;
  assign pwm_out  = kill_act ? ctrl_q.safe_o : db_out;
  assign pwm_nout = kill_act ? ctrl_q.safe_n : db_nout;
endmodule

// File: rtl/dbpwm_chk.sv
module dbpwm_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             kill_in,
  input logic             pwm_out,
  input logic             pwm_nout,
  input logic             safe_o,
  input logic             safe_n,
  input logic             db_out,
  input logic             db_nout,
  input logic             ovf,
  input logic             und,
  input logic             active,
  input logic             down,
  input logic             tc,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] per_sh
);
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(db_out && db_nout)); // R6

  AST_KILL_SAFE: assert property (@(posedge clk) disable iff (rst)
    kill_in |-> (pwm_out == safe_o && pwm_nout == safe_n)); // R9

  AST_WRAP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ovf && und)); // R2

  AST_OVF_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    (active && !down && count == per_sh) |=> ovf); // R1

  AST_UND_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (active && down && count == '0) |=> und); // R2

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    active |-> count <= per_sh); // R1

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (active && !tc) |=> $stable(per_sh)); // R7
endmodule

bind deadband_pwm dbpwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .kill_in(kill_in), .pwm_out(pwm_out),
  .pwm_nout(pwm_nout), .safe_o(ctrl_q.safe_o), .safe_n(ctrl_q.safe_n),
  .db_out(db_out), .db_nout(db_nout), .ovf(ovf), .und(und),
  .active(active), .down(ctrl_q.down), .tc(tc), .count(count), .per_sh(per_sh)
);

// File: tb/tb_deadband_pwm.sv
`timescale 1ns/1ps
module tb_deadband_pwm;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        cap_in = 1'b0;
  logic        kill_in = 1'b0;
  logic        pwm_out, pwm_nout, ovf, und, match;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int w_out, w_nout, w_both, w_ovf, w_und, w_match, w_overlap;

  always #4 clk = ~clk;

  deadband_pwm dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in),
    .kill_in(kill_in), .pwm_out(pwm_out), .pwm_nout(pwm_nout),
    .ovf(ovf), .und(und), .match(match)
  );

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output int d);
    reg_addr = a;
    @(negedge clk);
    d = int'(reg_rdata);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic window(int n);
    w_out = 0; w_nout = 0; w_both = 0; w_ovf = 0; w_und = 0; w_match = 0; w_overlap = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      w_out   += int'(pwm_out);
      w_nout  += int'(pwm_nout);
      w_both  += int'(!pwm_out && !pwm_nout);
      w_ovf   += int'(ovf);
      w_und   += int'(und);
      w_match += int'(match);
      w_overlap += int'(pwm_out && pwm_nout);
    end
  endtask

  task automatic wait_ovf(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ovf && n < 1000);
  endtask

  task automatic start(logic [15:0] ctrl, int per, int cmp, int dead);
    reg_write(3'd0, 16'h0);
    reg_write(3'd1, 16'(per));
    reg_write(3'd2, 16'(cmp));
    reg_write(3'd3, 16'(dead));
    reg_write(3'd0, ctrl);
    idle(20);
  endtask

  task automatic t_reset();
    int v;
    check_eq("R10 out in reset", int'(pwm_out), 0);
    check_eq("R10 nout in reset", int'(pwm_nout), 0);
    rst = 1'b0;
    idle(3);
    check_eq("R10 out idle", int'(pwm_out), 0);
    check_eq("R10 nout idle", int'(pwm_nout), 0);
    check_eq("R10 ovf idle", int'(ovf), 0);
    reg_read(3'd5, v);
    check_eq("R10 count after reset", v, 0);
  endtask

  task automatic t_up_basic();
    start(16'h0001, 9, 4, 0);
    window(50);
    check_eq("R1 ovf pulses in 5 periods", w_ovf, 5);
    check_eq("R1 und stays low", w_und, 0);
    check_eq("R4 out high cycles", w_out, 20);
    check_eq("R4 nout high cycles", w_nout, 30);
    check_eq("R5 match pulses", w_match, 5);
  endtask

  task automatic t_deadband();
    start(16'h0001, 9, 4, 3);
    window(50);
    check_eq("R6 out high with dead time", w_out, 5);
    check_eq("R6 nout high with dead time", w_nout, 15);
    check_eq("R6 both low cycles", w_both, 30);
    check_eq("R6 no overlap", w_overlap, 0);
  endtask

  task automatic t_buffered();
    int n1, n2, n0;
    start(16'h0001, 9, 4, 0);
    wait_ovf(n0);
    reg_write(3'd1, 16'd14);
    wait_ovf(n1);
    check_eq("R7 interval keeps old period", n1 + 1, 10);
    wait_ovf(n2);
    check_eq("R7 interval uses new period", n2, 15);
    reg_write(3'd2, 16'd6);
    idle(40);
    window(60);
    check_eq("R7 new compare after wrap", w_out, 24);
  endtask

  task automatic t_down();
    start(16'h0005, 9, 4, 0);
    window(50);
    check_eq("R2 und pulses", w_und, 5);
    check_eq("R2 ovf stays low", w_ovf, 0);
    check_eq("R4 duty counting down", w_out, 20);
  endtask

  task automatic t_oneshot_capture();
    int v;
    start(16'h0000, 9, 4, 0);
    reg_write(3'd0, 16'h0003);
    window(40);
    check_eq("R3 single wrap", w_ovf, 1);
    reg_read(3'd0, v);
    check_eq("R3 run bit cleared", v & 1, 0);
    reg_read(3'd5, v);
    check_eq("R3 count holds at period", v, 9);
    cap_in = 1'b1;
    idle(2);
    cap_in = 1'b0;
    idle(6);
    reg_read(3'd4, v);
    check_eq("R8 captured count", v, 9);
    start(16'h0000, 7, 2, 0);
    reg_write(3'd0, 16'h0007);
    idle(30);
    reg_read(3'd5, v);
    check_eq("R3 down single-shot holds zero", v, 0);
    cap_in = 1'b1;
    idle(2);
    cap_in = 1'b0;
    idle(6);
    reg_read(3'd4, v);
    check_eq("R8 second capture", v, 0);
  endtask

  task automatic t_kill();
    int n;
    int bad;
    start(16'h0011, 9, 4, 0);
    idle(3);
    kill_in = 1'b1;
    #1;
    check_eq("R9 out forced without edge", int'(pwm_out), 0);
    check_eq("R9 nout forced without edge", int'(pwm_nout), 1);
    window(7);
    check_eq("R9 held safe out", w_out, 0);
    check_eq("R9 held safe nout", w_nout, 7);
    wait_ovf(n);
    idle(3);
    kill_in = 1'b0;
    #1;
    check_eq("R9 still safe after release", int'(pwm_nout), 1);
    bad = 0;
    n = 0;
    while (!ovf && n < 100) begin
      if (pwm_out != 1'b0 || pwm_nout != 1'b1) bad++;
      @(negedge clk);
      n++;
    end
    check_eq("R9 safe until wrap", bad, 0);
    idle(10);
    window(50);
    check_eq("R9 normal drive resumes", w_out, 20);
  endtask

  task automatic t_readback();
    int v;
    reg_write(3'd0, 16'h0000);
    reg_write(3'd3, 16'h00A5);
    reg_read(3'd3, v);
    check_eq("R11 dead time readback", v, 165);
    reg_write(3'd1, 16'h1234);
    reg_read(3'd1, v);
    check_eq("R11 period readback", v, 4660);
    reg_write(3'd2, 16'hBEEF);
    reg_read(3'd2, v);
    check_eq("R11 compare readback", v, 48879);
    reg_write(3'd0, 16'h0018);
    reg_read(3'd0, v);
    check_eq("R11 control readback", v, 24);
    idle(3);
    check_eq("R10 stopped out low", int'(pwm_out), 0);
    check_eq("R10 stopped nout low", int'(pwm_nout), 0);
  endtask

  initial begin
    idle(4);
    t_reset();
    t_up_basic();
    t_deadband();
    t_buffered();
    t_down();
    t_oneshot_capture();
    t_kill();
    t_readback();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule